// File: doc/BRIEF.md
# Pixel to Bus-Beat Packer

This block sits between a pixel stream and a parallel-bus timing engine for a command-mode display panel. Each pixel arrives on a valid/ready stream. The block splits it into one or more data beats as wide as the selected number of bus lines. The beats go out on a second valid/ready stream, and the timing engine turns each one into a write strobe. A frame is a fixed number of pixels, normally the width of the update area times its height.

Software sets a pixel-size code, a bus-width code and a pixel count, then pulses `start`. The block latches those settings and picks a cycle format from the ratio of pixel bits to bus lines. It then accepts exactly the programmed number of pixels and sends their bits most significant first. When the last beat has been taken, it pulses `frame_done` and drops `busy`. A size and width pair that cannot be packed is refused at start: `cfg_err` is raised and no beat is sent.

The block also handles the case where one and a half bus words make up a pixel. It gathers two pixels and sends them as three beats, and the middle beat carries half a word from each pixel.

Top module: `pix_beat_packer`

## Requirements
- R1: Pixel-size code 0/1/2/3 means 12/16/18/24 bits, and bus-width code 0/1/2/3 means 8/9/12/16 lines. The cycle format reported on `cyc_fmt` is as follows. Code 0 is used when the bits equal the lines, code 1 when they are twice the lines, and code 2 when they are three times the lines. Code 3 is used when twice the bits is three times the lines. Every other pair is unsupported.
- R2: In formats 0, 1 and 2, beat k of a pixel with P bits on L lines carries pixel bits [P-1-k*L : P-L-k*L]. So 16 bits on 8 lines sends [15:8] then [7:0], and 24 bits on 8 lines sends [23:16], [15:8], [7:0].
- R3: In format 3, pixels are packed in pairs into three beats. Beat 0 is the top L bits of the first pixel. Beat 1 is the low L/2 bits of the first pixel above the top L/2 bits of the second. Beat 2 is the low L bits of the second pixel.
- R4: A beat occupies `beat_data[L-1:0]` and its higher bits are zero. Bits of `pix_data` above the pixel size have no effect on any beat.
- R5: While `beat_valid` is high and `beat_ready` is low, `beat_data` holds its value. `pix_ready` is low while a group of beats is being sent.
- R6: A start latches the codes and `pix_count` and raises `busy` on the next cycle. Exactly `pix_count` pixels are then accepted, and `pix_ready` stays low after the last one.
- R7: `frame_done` is high for exactly one cycle, the cycle after the last beat of the frame is accepted. `busy` goes low in that same cycle.
- R8: A start is refused in three cases: an unsupported pair, a zero count, or an odd count in format 3. In that case `cfg_err` is high from the next cycle until the next accepted start, `busy` stays low, and no pixel or beat is accepted.
- R9: After reset, `busy`, `pix_ready`, `beat_valid`, `frame_done` and `cfg_err` are all low.
- R10: A start while `busy` is high is ignored. The running frame keeps its format, count and beat order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a frame with the settings present on this cycle |
| dtype | input | 2 | Pixel-size code |
| bwidth | input | 2 | Bus-width code |
| pix_count | input | CNT_W | Number of pixels in the frame |
| pix_valid | input | 1 | Pixel offered |
| pix_ready | output | 1 | Pixel taken when high together with pix_valid |
| pix_data | input | 24 | Pixel, right-aligned |
| beat_valid | output | 1 | Beat offered to the bus timer |
| beat_ready | input | 1 | Bus timer takes the beat |
| beat_data | output | 16 | Beat, right-aligned to the bus width |
| busy | output | 1 | Frame in progress |
| cyc_fmt | output | 2 | Cycle format of the latched settings |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| cfg_err | output | 1 | Last start was refused |

## Verification
The bench builds the packer with `CNT_W` set to 10 instead of the default 16. All 16 code pairs are run with short six-pixel frames. Longer frames of 40 and 50 pixels use a random `beat_ready`, which exercises the back-pressure paths of R5 and R10 within a short run. The odd count and the zero count that lead to refusal both fit in this width. The expected beats are produced by streaming the pixel bits most significant first and cutting them into pieces as wide as the bus, so the bench does not repeat the format table.

// File: rtl/pk_pkg.sv
`timescale 1ns/1ps
package pk_pkg;
  localparam int PIX_MAX = 24;
  localparam int BUS_MAX = 16;
  localparam int GRP_W   = 2 * PIX_MAX;

  typedef enum logic [1:0] {
    CF_ONE   = 2'd0,
    CF_TWO   = 2'd1,
    CF_THREE = 2'd2,
    CF_PAIR  = 2'd3
  } cyc_fmt_e;

  typedef struct packed {
    logic      bad;
    cyc_fmt_e  fmt;
    logic [4:0] pbits;
    logic [4:0] lines;
    logic [1:0] nbeats;
    logic [1:0] npix;
  } fmt_t;

  function automatic logic [4:0] bits_of(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd12;
      2'd1:    return 5'd16;
      2'd2:    return 5'd18;
      default: return 5'd24;
    endcase
  endfunction

  function automatic logic [4:0] lines_of(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd8;
      2'd1:    return 5'd9;
      2'd2:    return 5'd12;
      default: return 5'd16;
    endcase
  endfunction

  // Ratio of pixel bits to lines picks the format; 1.5 selects pair packing.
  function automatic fmt_t decode_fmt(input logic [1:0] dtype, input logic [1:0] bwidth);
    fmt_t f;
    int p;
    int l;
    f = '0;
    f.pbits = bits_of(dtype);
    f.lines = lines_of(bwidth);
    p = int'(f.pbits);
    l = int'(f.lines);
    f.nbeats = 2'd1;
    f.npix   = 2'd1;
    if ((p % l) == 0) begin
      f.fmt    = cyc_fmt_e'(2'(p / l - 1));
      f.nbeats = 2'(p / l);
    end else if (((2 * p) % l) == 0 && ((2 * p) / l) == 3) begin
      f.fmt    = CF_PAIR;
      f.nbeats = 2'd3;
      f.npix   = 2'd2;
    end else begin
      f.bad = 1'b1;
    end
    return f;
  endfunction

  function automatic logic [PIX_MAX-1:0] clip_pix(input logic [PIX_MAX-1:0] d,
                                                  input logic [4:0] p);
    return d & ~({PIX_MAX{1'b1}} << p);
  endfunction

  // Beat idx of a group is the idx-th L-bit slice counted from the top.
  function automatic logic [BUS_MAX-1:0] slice_beat(input logic [GRP_W-1:0] grp,
                                                    input fmt_t f,
                                                    input logic [1:0] idx);
    int sh;
    sh = (int'(f.nbeats) - 1 - int'(idx)) * int'(f.lines);
    if (sh < 0) sh = 0;
    return BUS_MAX'(grp >> sh) & ~({BUS_MAX{1'b1}} << f.lines);
  endfunction
endpackage

// File: rtl/pk_fmt_decode.sv
`timescale 1ns/1ps
module pk_fmt_decode
  import pk_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [1:0]       dtype_i,
  input  logic [1:0]       bwidth_i,
  input  logic [CNT_W-1:0] count_i,
  output fmt_t             fmt_o,
  output logic             reject_o
);
  always_comb begin
    fmt_o    = decode_fmt(dtype_i, bwidth_i);
    reject_o = fmt_o.bad | (count_i == '0) | ((fmt_o.npix == 2'd2) & count_i[0]);
  end
endmodule

// File: rtl/pk_frame_ctl.sv
`timescale 1ns/1ps
module pk_frame_ctl
  import pk_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             reject_i,
  input  fmt_t             fmt_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             pix_fire_i,
  input  logic             grp_done_i,
  output fmt_t             fmt_q,
  output logic             busy_o,
  output logic             more_pix_o,
  output logic             frame_done_o,
  output logic             cfg_err_o
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] taken_q;
  logic             busy_q;
  logic             done_q;
  logic             err_q;
  logic             start_ok;
  logic             all_taken;

  assign start_ok   = start_i & ~busy_q;
  assign all_taken  = (taken_q == count_q);
  assign more_pix_o = busy_q & ~all_taken;
  assign busy_o     = busy_q;
  assign frame_done_o = done_q;
  assign cfg_err_o  = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      taken_q <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      fmt_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_ok) begin
        err_q   <= reject_i;
        busy_q  <= ~reject_i;
        fmt_q   <= fmt_i;
        count_q <= count_i;
        taken_q <= '0;
      end else if (busy_q) begin
        if (pix_fire_i) taken_q <= taken_q + CNT_W'(1);
        if (grp_done_i && all_taken) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_busy_ends_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);
  assert_err_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !busy_q);
  assert_taken_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (taken_q <= count_q));
  assert_busy_format_ok_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !fmt_q.bad);
endmodule

// File: rtl/pk_beat_seq.sv
`timescale 1ns/1ps
module pk_beat_seq
  import pk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  fmt_t               fmt_i,
  input  logic [PIX_MAX-1:0] pix_data_i,
  input  logic               pix_fire_i,
  input  logic               more_pix_i,
  input  logic               beat_ready_i,
  output logic               pix_ready_o,
  output logic               beat_valid_o,
  output logic [BUS_MAX-1:0] beat_data_o,
  output logic               grp_done_o
);
  logic [GRP_W-1:0] grp_q;
  logic             emit_q;
  logic [1:0]       idx_q;
  logic [1:0]       held_q;
  logic             beat_fire;

  assign pix_ready_o  = more_pix_i & ~emit_q;
  assign beat_valid_o = emit_q;
  assign beat_data_o  = slice_beat(grp_q, fmt_i, idx_q);
  assign beat_fire    = emit_q & beat_ready_i;
  assign grp_done_o   = beat_fire & (idx_q == fmt_i.nbeats - 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q  <= '0;
      emit_q <= 1'b0;
      idx_q  <= '0;
      held_q <= '0;
    end else if (pix_fire_i) begin
      grp_q <= (grp_q << fmt_i.pbits) | GRP_W'(clip_pix(pix_data_i, fmt_i.pbits));
      if (held_q + 2'd1 == fmt_i.npix) begin
        emit_q <= 1'b1;
        idx_q  <= '0;
        held_q <= '0;
      end else begin
        held_q <= held_q + 2'd1;
      end
    end else if (beat_fire) begin
      if (grp_done_o) emit_q <= 1'b0;
      else            idx_q  <= idx_q + 2'd1;
    end
  end

  assert_beat_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && !beat_ready_i) |=> (beat_valid_o && $stable(beat_data_o)));
  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid_o |-> ((beat_data_o >> fmt_i.lines) == '0));
  assert_idx_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    emit_q |-> (idx_q < fmt_i.nbeats));
  assert_no_intake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pix_fire_i |-> !beat_valid_o);
endmodule

// File: rtl/pix_beat_packer.sv
`timescale 1ns/1ps
module pix_beat_packer
  import pk_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       dtype,
  input  logic [1:0]       bwidth,
  input  logic [CNT_W-1:0] pix_count,
  input  logic             pix_valid,
  output logic             pix_ready,
  input  logic [23:0]      pix_data,
  output logic             beat_valid,
  input  logic             beat_ready,
  output logic [15:0]      beat_data,
  output logic             busy,
  output logic [1:0]       cyc_fmt,
  output logic             frame_done,
  output logic             cfg_err
);
  fmt_t fmt_new;
  fmt_t fmt_cur;
  logic reject;
  logic more_pix;
  logic pix_fire;
  logic grp_done;

  assign pix_fire = pix_valid & pix_ready;
  assign cyc_fmt  = fmt_cur.fmt;

  pk_fmt_decode #(.CNT_W(CNT_W)) u_dec (
    .dtype_i  (dtype),
    .bwidth_i (bwidth),
    .count_i  (pix_count),
    .fmt_o    (fmt_new),
    .reject_o (reject)
  );

  pk_frame_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .reject_i     (reject),
    .fmt_i        (fmt_new),
    .count_i      (pix_count),
    .pix_fire_i   (pix_fire),
    .grp_done_i   (grp_done),
    .fmt_q        (fmt_cur),
    .busy_o       (busy),
    .more_pix_o   (more_pix),
    .frame_done_o (frame_done),
    .cfg_err_o    (cfg_err)
  );

  pk_beat_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .fmt_i        (fmt_cur),
    .pix_data_i   (pix_data),
    .pix_fire_i   (pix_fire),
    .more_pix_i   (more_pix),
    .beat_ready_i (beat_ready),
    .pix_ready_o  (pix_ready),
    .beat_valid_o (beat_valid),
    .beat_data_o  (beat_data),
    .grp_done_o   (grp_done)
  );

  assert_err_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!beat_valid && !pix_ready));
  assert_fmt_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(cyc_fmt));
endmodule

// File: tb/pix_beat_packer_tb.sv
`timescale 1ns/1ps
module pix_beat_packer_tb;
  localparam int CNT_W = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n, start, pix_valid, beat_ready;
  logic [1:0]       dtype, bwidth;
  logic [CNT_W-1:0] pix_count;
  logic [23:0]      pix_data;
  logic             pix_ready, beat_valid, busy, frame_done, cfg_err;
  logic [15:0]      beat_data;
  logic [1:0]       cyc_fmt;

  pix_beat_packer #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dtype(dtype), .bwidth(bwidth),
    .pix_count(pix_count), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_data(pix_data), .beat_valid(beat_valid), .beat_ready(beat_ready),
    .beat_data(beat_data), .busy(busy), .cyc_fmt(cyc_fmt),
    .frame_done(frame_done), .cfg_err(cfg_err)
  );

  int n_checks = 0;
  int n_fail   = 0;
  logic [15:0] exp_q[$];
  logic [31:0] dseed = 32'h1ACE_B00C;
  logic [31:0] rseed = 32'h0BAD_F00D;
  int ready_mode = 0;
  int cur_lines  = 8;
  int cur_code   = 0;
  int done_seen  = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  function automatic int bpp(input logic [1:0] c);
    case (c) 2'd0: return 12; 2'd1: return 16; 2'd2: return 18; default: return 24; endcase
  endfunction

  function automatic int lns(input logic [1:0] c);
    case (c) 2'd0: return 8; 2'd1: return 9; 2'd2: return 12; default: return 16; endcase
  endfunction

  // Supported pairs written out by hand; -1 marks refusal.
  function automatic int exp_code(input logic [1:0] dt, input logic [1:0] bw);
    case ({dt, bw})
      4'b00_00: return 3;
      4'b00_10: return 0;
      4'b01_00: return 1;
      4'b01_11: return 0;
      4'b10_01: return 1;
      4'b10_10: return 3;
      4'b11_00: return 2;
      4'b11_10: return 1;
      4'b11_11: return 3;
      default:  return -1;
    endcase
  endfunction

  // Back-pressure source
  initial begin
    beat_ready = 1'b0;
    forever begin
      @(posedge clk); #1;
      rseed = nxt(rseed);
      beat_ready = (ready_mode == 0) ? 1'b1 : rseed[3];
    end
  end

  // Monitor: pops the scoreboard on each accepted beat
  initial begin
    logic prev_stall;
    logic [15:0] prev_data;
    logic [15:0] e;
    prev_stall = 1'b0;
    prev_data  = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (frame_done) done_seen++;
        if (prev_stall)
          check(beat_valid && beat_data == prev_data, "R5 beat held under stall",
                {beat_valid, beat_data}, {1'b1, prev_data});
        if (beat_valid)
          check(!pix_ready, "R5 no pixel intake while sending", pix_ready, 0);
        if (beat_valid && beat_ready) begin
          check((beat_data >> cur_lines) == 0, "R4 bits above bus width zero", beat_data, 0);
          if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected beat", beat_data, 0);
          end else begin
            e = exp_q.pop_front();
            if (cur_code == 3) check(beat_data == e, "R3 pair-packed beat", beat_data, e);
            else               check(beat_data == e, "R2 beat data", beat_data, e);
          end
        end
        prev_stall = beat_valid && !beat_ready;
        prev_data  = beat_data;
      end
    end
  end

  task automatic run_frame(input logic [1:0] dt, input logic [1:0] bw, input int n,
                           input int rmode, input bit poke);
    int p;
    int l;
    int code;
    bit bq[$];
    logic [23:0] px[$];
    logic [15:0] v;
    bit acc;
    int guard;
    p = bpp(dt);
    l = lns(bw);
    code = exp_code(dt, bw);
    for (int i = 0; i < n; i++) begin
      dseed = nxt(nxt(dseed));
      px.push_back(dseed[23:0]);
      for (int b = p - 1; b >= 0; b--) bq.push_back(dseed[b]);
    end
    @(posedge clk); #1;
    dtype = dt; bwidth = bw; pix_count = CNT_W'(n); start = 1'b1;
    if (code < 0 || n == 0 || (code == 3 && (n % 2) == 1)) begin
      @(posedge clk); #1;
      start = 1'b0; pix_valid = 1'b1; pix_data = dseed[23:0];
      @(negedge clk);
      check(cfg_err == 1'b1, "R8 refusal flagged", cfg_err, 1);
      check(busy == 1'b0, "R8 no frame on refusal", busy, 0);
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        check(!beat_valid && !pix_ready, "R8 nothing moves after refusal",
              {beat_valid, pix_ready}, 0);
      end
      @(posedge clk); #1;
      pix_valid = 1'b0;
      return;
    end
    ready_mode = rmode;
    cur_lines  = l;
    cur_code   = code;
    while (bq.size() >= l) begin
      v = '0;
      for (int b = 0; b < l; b++) v = {v[14:0], bq.pop_front()};
      exp_q.push_back(v);
    end
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    check(cyc_fmt == 2'(code), "R1 cycle format", cyc_fmt, code);
    check(busy == 1'b1, "R6 busy after start", busy, 1);
    check(cfg_err == 1'b0, "R8 error cleared by good start", cfg_err, 0);
    done_seen = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      start = 1'b0;
      pix_valid = 1'b1;
      pix_data  = px[i];
      if (poke && i == 1) begin
        start = 1'b1; dtype = dt ^ 2'b01; bwidth = bw ^ 2'b10; pix_count = CNT_W'(3);
      end
      acc = 1'b0;
      while (!acc) begin
        @(negedge clk);
        acc = pix_ready;
        if (!acc) begin @(posedge clk); #1; end
      end
    end
    @(posedge clk); #1;
    start = 1'b0;
    dseed = nxt(dseed);
    pix_data = dseed[23:0];
    guard = 0;
    while (1) begin
      @(negedge clk);
      if (frame_done) break;
      check(!pix_ready, "R6 no pixel beyond count", pix_ready, 0);
      guard++;
      if (guard > 3000) begin
        check(1'b0, "R7 frame_done missing", 0, 1);
        break;
      end
    end
    check(exp_q.size() == 0, "R7 all beats out at frame_done", exp_q.size(), 0);
    check(busy == 1'b0, "R7 busy drops with frame_done", busy, 0);
    if (poke) check(cyc_fmt == 2'(code), "R10 start while busy ignored", cyc_fmt, code);
    @(negedge clk);
    check(frame_done == 1'b0, "R7 frame_done one cycle", frame_done, 0);
    check(done_seen == 1, "R7 single done pulse", done_seen, 1);
    check(!pix_ready, "R6 intake closed after frame", pix_ready, 0);
    @(posedge clk); #1;
    pix_valid = 1'b0;
    exp_q.delete();
  endtask

  initial begin
    #(200000 * 4);
    check(1'b0, "watchdog run did not finish", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; pix_valid = 1'b0; pix_data = '0;
    dtype = '0; bwidth = '0; pix_count = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy && !pix_ready && !beat_valid && !frame_done && !cfg_err,
          "R9 reset state", {busy, pix_ready, beat_valid, frame_done, cfg_err}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    for (int d = 0; d < 4; d++)
      for (int w = 0; w < 4; w++)
        run_frame(2'(d), 2'(w), 6, (d + w) % 2, 1'b0);
    run_frame(2'd0, 2'd0, 5, 1, 1'b0);   // odd count in pair mode
    run_frame(2'd1, 2'd3, 0, 0, 1'b0);   // zero count
    run_frame(2'd3, 2'd0, 40, 1, 1'b1);
    run_frame(2'd2, 2'd2, 50, 1, 1'b1);
    run_frame(2'd3, 2'd3, 20, 1, 1'b0);
    run_frame(2'd1, 2'd0, 10, 0, 1'b0);
    repeat (4) @(posedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule